// File: doc/BRIEF.md
# GPIO Bank Register Interface

This block is the register front end of a general purpose I/O bank of up to 32 pins. A simple word-addressed bus with address, write enable, write data and combinational read data configures each pin independently. Per pin, software picks general I/O or interrupt input, input or output direction, the logic polarity that the interrupt logic sees, the source of the driven value, and whether the input buffer is enabled at all.

On the pin side the block drives the pad value and output enable and samples the pad input through a two-stage synchronizer. The synchronized, enable-gated level is readable over the bus even for pins that are currently driving, so software sees the real line level. The same gated level, after polarity correction, is passed to a separate interrupt detection block together with the per-pin interrupt-mode selects. The value to be driven can be loaded before a pin is turned into an output, so the pin comes up driving the intended level.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration register reads 0, so all pins are general-I/O inputs with positive logic, pad_oe and pad_out are 0, input enables are 0 and intr_level is 0.
- R2: Writes to the word offsets 0x00 (interrupt-mode select), 0x04 (direction), 0x08 (output value), 0x20 (polarity), 0x40 (drive source) and 0x50 (input enable) update that register the next clock; bit n always controls pin n, and each reads back what was written.
- R3: pad_oe[n] is 1 exactly when direction bit n is 1 (1 = output) and interrupt-mode bit n is 0; a pin in interrupt mode never drives.
- R4: pad_out[n] follows output-value bit n when drive-source bit n is 0 and alt_data[n] when it is 1, whether or not the pin is enabled, so a value written before the direction change appears at once when pad_oe rises.
- R5: Offset 0x0C reads pad_in after two clock edges of synchronization, ANDed with the input-enable register; this includes pins configured as outputs.
- R6: intr_level[n] equals the synchronized pad_in[n] XOR polarity bit n (1 = active low), forced to 0 when input-enable bit n is 0; intr_mode mirrors the interrupt-mode select register.
- R7: Bits at and above NUM_PINS read 0 in every register, ignore writes, and hold pad_oe, pad_out and intr_level at 0.
- R8: Reads of any offset not listed in R2 or R5, including byte addresses that are not word aligned, return 0; writes to the read-only offset 0x0C change nothing.
- R9: A write to an unmapped offset changes no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pad_in | input | DATA_W | Raw pad input levels |
| alt_data | input | DATA_W | Alternative drive value from another function |
| pad_out | output | DATA_W | Value driven toward the pads |
| pad_oe | output | DATA_W | Per-pin pad output enable |
| intr_level | output | DATA_W | Synchronized, gated, polarity-corrected level for the interrupt logic |
| intr_mode | output | DATA_W | Per-pin interrupt-mode select for the interrupt logic |

## Verification
The bench builds the bank with NUM_PINS set to 24 while the data path stays 32 bits wide, so eight unimplemented bit positions exist and the masking of writes, reads and pin outputs in R7 can be observed directly. The default 32-pin build has no such bits, so only the 24-pin build reaches those checks. With that width a behavioural model of every register and of the two-stage synchronizer is compared against all outputs on every clock, while directed sequences walk through write-before-enable, interrupt-mode override of the output enable, input gating and polarity, and the one-cycle-short read that exposes synchronizer depth.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_ODATA,
        SEL_IDATA,
        SEL_POL,
        SEL_SRC,
        SEL_IEN
    } reg_sel_e;

    localparam int unsigned OFF_MODE  = 32'h00;
    localparam int unsigned OFF_DIR   = 32'h04;
    localparam int unsigned OFF_ODATA = 32'h08;
    localparam int unsigned OFF_IDATA = 32'h0C;
    localparam int unsigned OFF_POL   = 32'h20;
    localparam int unsigned OFF_SRC   = 32'h40;
    localparam int unsigned OFF_IEN   = 32'h50;

    localparam int unsigned NUM_CFG = 6;

    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        reg_sel_e sel;
        case (byte_addr)
            OFF_MODE:  sel = SEL_MODE;
            OFF_DIR:   sel = SEL_DIR;
            OFF_ODATA: sel = SEL_ODATA;
            OFF_IDATA: sel = SEL_IDATA;
            OFF_POL:   sel = SEL_POL;
            OFF_SRC:   sel = SEL_SRC;
            OFF_IEN:   sel = SEL_IEN;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic reg_sel_e cfg_slot(input int unsigned idx);
        reg_sel_e sel;
        case (idx)
            0:       sel = SEL_MODE;
            1:       sel = SEL_DIR;
            2:       sel = SEL_ODATA;
            3:       sel = SEL_POL;
            4:       sel = SEL_SRC;
            5:       sel = SEL_IEN;
            default: sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] odata_q,
    output logic [DATA_W-1:0] pol_q,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] ien_q
);
    localparam logic [DATA_W-1:0] VALID_MASK = {DATA_W{1'b1}} >> (DATA_W - NUM_PINS);

    logic [DATA_W-1:0] cfg_q [NUM_CFG];

    for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
        localparam reg_sel_e MY_SEL = cfg_slot(r);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[r] <= '0;
            end else if (wr_en && (sel == MY_SEL)) begin
                cfg_q[r] <= wdata & VALID_MASK;
            end
        end
    end

    assign mode_q  = cfg_q[0];
    assign dir_q   = cfg_q[1];
    assign odata_q = cfg_q[2];
    assign pol_q   = cfg_q[3];
    assign src_q   = cfg_q[4];
    assign ien_q   = cfg_q[5];
endmodule

// File: rtl/gpb_pad.sv
module gpb_pad #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32
) (
    input  logic [DATA_W-1:0] mode_q,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] odata_q,
    input  logic [DATA_W-1:0] pol_q,
    input  logic [DATA_W-1:0] src_q,
    input  logic [DATA_W-1:0] ien_q,
    input  logic [DATA_W-1:0] alt_data,
    input  logic [DATA_W-1:0] pad_sync,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic [DATA_W-1:0] in_seen,
    output logic [DATA_W-1:0] intr_level
);
    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
        if (p < NUM_PINS) begin : g_live
            // A pin in interrupt mode is a pure input regardless of direction.
            assign pad_oe[p]     = dir_q[p] & ~mode_q[p];
            assign pad_out[p]    = src_q[p] ? alt_data[p] : odata_q[p];
            assign in_seen[p]    = pad_sync[p] & ien_q[p];
            assign intr_level[p] = (pad_sync[p] ^ pol_q[p]) & ien_q[p];
        end else begin : g_absent
            assign pad_oe[p]     = 1'b0;
            assign pad_out[p]    = 1'b0;
            assign in_seen[p]    = 1'b0;
            assign intr_level[p] = 1'b0;
        end
    end
endmodule

// File: rtl/gpb_rmux.sv
module gpb_rmux
    import gpb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] mode_q,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] odata_q,
    input  logic [DATA_W-1:0] in_seen,
    input  logic [DATA_W-1:0] pol_q,
    input  logic [DATA_W-1:0] src_q,
    input  logic [DATA_W-1:0] ien_q,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (sel)
            SEL_MODE:  rdata = mode_q;
            SEL_DIR:   rdata = dir_q;
            SEL_ODATA: rdata = odata_q;
            SEL_IDATA: rdata = in_seen;
            SEL_POL:   rdata = pol_q;
            SEL_SRC:   rdata = src_q;
            SEL_IEN:   rdata = ien_q;
            SEL_NONE:  rdata = '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    input  logic [DATA_W-1:0] alt_data,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic [DATA_W-1:0] intr_level,
    output logic [DATA_W-1:0] intr_mode
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] mode_q, dir_q, odata_q, pol_q, src_q, ien_q;
    logic [DATA_W-1:0] pad_sync, in_seen;

    // Full byte address is decoded: misaligned addresses select nothing.
    assign sel = decode_addr(32'(bus_addr));

    gpb_regs #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .sel     (sel),
        .wdata   (bus_wdata),
        .mode_q  (mode_q),
        .dir_q   (dir_q),
        .odata_q (odata_q),
        .pol_q   (pol_q),
        .src_q   (src_q),
        .ien_q   (ien_q)
    );

    gpb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    gpb_pad #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_pad (
        .mode_q     (mode_q),
        .dir_q      (dir_q),
        .odata_q    (odata_q),
        .pol_q      (pol_q),
        .src_q      (src_q),
        .ien_q      (ien_q),
        .alt_data   (alt_data),
        .pad_sync   (pad_sync),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .in_seen    (in_seen),
        .intr_level (intr_level)
    );

    gpb_rmux #(.DATA_W(DATA_W)) u_rmux (
        .sel     (sel),
        .mode_q  (mode_q),
        .dir_q   (dir_q),
        .odata_q (odata_q),
        .in_seen (in_seen),
        .pol_q   (pol_q),
        .src_q   (src_q),
        .ien_q   (ien_q),
        .rdata   (bus_rdata)
    );

    assign intr_mode = mode_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pad_oe,
    input logic [DATA_W-1:0] intr_level,
    input logic [DATA_W-1:0] ien_q
);
    localparam logic [DATA_W-1:0] VALID_MASK = {DATA_W{1'b1}} >> (DATA_W - NUM_PINS);

    logic unmapped;
    assign unmapped = (decode_addr(32'(bus_addr)) == SEL_NONE);

    // R1: while reset is held no pin drives and nothing reaches the interrupt logic
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (pad_oe == '0 && intr_level == '0)
                else $error("reset outputs not quiet");
        end
    end

    p_intmode_blocks_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_MODE)) |=> ((pad_oe & $past(bus_wdata)) == '0));

    p_intr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((intr_level & ~ien_q) == '0));

    p_high_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((bus_rdata | pad_oe | intr_level) & ~VALID_MASK) == '0));

    p_unmapped_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

    p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unmapped) |=> $stable(pad_oe));
endmodule

bind gpio_bank gpio_bank_chk #(
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .intr_level (intr_level),
    .ien_q      (ien_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
    localparam logic [31:0] VM = 32'h00FF_FFFF;   // 24 pins

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] alt_data = '0;
    logic [31:0] pad_out, pad_oe, intr_level, intr_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_bank #(.DATA_W(32), .NUM_PINS(24), .ADDR_W(8), .SYNC_LEN(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_data(alt_data), .pad_out(pad_out), .pad_oe(pad_oe),
        .intr_level(intr_level), .intr_mode(intr_mode)
    );

    // Behavioural reference model
    logic [31:0] m_mode, m_dir, m_od, m_pol, m_src, m_ien, m_s1, m_s2;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; m_dir <= 0; m_od <= 0; m_pol <= 0;
            m_src <= 0; m_ien <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_mode <= bus_wdata & VM;
                    8'h04: m_dir  <= bus_wdata & VM;
                    8'h08: m_od   <= bus_wdata & VM;
                    8'h20: m_pol  <= bus_wdata & VM;
                    8'h40: m_src  <= bus_wdata & VM;
                    8'h50: m_ien  <= bus_wdata & VM;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_mode;
            8'h04: return m_dir;
            8'h08: return m_od;
            8'h0C: return m_s2 & m_ien & VM;
            8'h20: return m_pol;
            8'h40: return m_src;
            8'h50: return m_ien;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison, 2 ns before the rising edge
    always @(negedge clk) begin
        #8;
        if (rst_n && !finished) begin
            chk("R3 pad_oe model", pad_oe, m_dir & ~m_mode & VM);
            chk("R4 pad_out model", pad_out, ((m_src & alt_data) | (~m_src & m_od)) & VM);
            chk("R6 intr_level model", intr_level, (m_s2 ^ m_pol) & m_ien & VM);
            chk("R2 intr_mode model", intr_mode, m_mode);
            chk("R8 bus_rdata model", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #4;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R1 reset state
        rd(8'h00, 0, "R1 mode reset");
        rd(8'h04, 0, "R1 dir reset");
        rd(8'h08, 0, "R1 odata reset");
        rd(8'h0C, 0, "R1 idata reset");
        rd(8'h20, 0, "R1 pol reset");
        rd(8'h40, 0, "R1 src reset");
        rd(8'h50, 0, "R1 ien reset");
        chk("R1 pad_oe reset", pad_oe, 0);
        chk("R1 pad_out reset", pad_out, 0);

        // R4 write-before-enable
        wr(8'h08, 32'hA5A5_A5A5);
        #4;
        chk("R4 preload out", pad_out, 32'h00A5_A5A5);
        chk("R4 preload oe off", pad_oe, 0);
        rd(8'h08, 32'h00A5_A5A5, "R2 odata readback");
        wr(8'h04, 32'h0000_FFFF);
        #4;
        chk("R3 dir enables oe", pad_oe, 32'h0000_FFFF);
        chk("R4 value held at enable", pad_out, 32'h00A5_A5A5);

        // R3 interrupt mode overrides direction
        wr(8'h00, 32'h0000_00F0);
        #4;
        chk("R3 intmode blocks oe", pad_oe, 32'h0000_FF0F);
        chk("R2 intr_mode", intr_mode, 32'h0000_00F0);

        // R5 input gated off
        pad_in = 32'hFF5A_1234;
        settle(2);
        rd(8'h0C, 0, "R5 idata gated by ien");
        chk("R6 intr gated", intr_level, 0);

        // R7 masking and R5 visibility including output pins
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'h00FF_FFFF, "R7 ien upper bits");
        rd(8'h0C, 32'h005A_1234, "R5 idata with outputs");

        wr(8'h50, 32'h0000_00FF);
        rd(8'h0C, 32'h0000_0034, "R5 idata partial ien");
        chk("R6 intr partial ien", intr_level, 32'h0000_0034);

        // R6 polarity
        wr(8'h20, 32'h0000_000F);
        #4;
        chk("R6 polarity", intr_level, 32'h0000_003B);

        // R4 alternative source
        alt_data = 32'h00C3_C3C3;
        wr(8'h40, 32'h0000_FF00);
        #4;
        chk("R4 alt source", pad_out, 32'h00A5_C3A5);

        // R8 unmapped and read-only
        rd(8'h10, 0, "R8 unmapped 0x10");
        rd(8'h30, 0, "R8 unmapped 0x30");
        rd(8'h02, 0, "R8 misaligned");
        rd(8'hFC, 0, "R8 unmapped 0xFC");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0000_0034, "R8 idata read only");

        // R9 stray write
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_00F0, "R9 mode untouched");
        rd(8'h04, 32'h0000_FFFF, "R9 dir untouched");
        chk("R9 pad_oe untouched", pad_oe, 32'h0000_FF0F);

        // R5 synchronizer depth
        pad_in = 32'h0000_00C1;
        settle(1);
        rd(8'h0C, 32'h0000_0034, "R5 one edge still old");
        settle(1);
        rd(8'h0C, 32'h0000_00C1, "R5 two edges new");

        // R7 upper pin bits on outputs
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h00FF_FFFF, "R7 dir upper bits");
        #1;
        chk("R7 pad_oe upper", pad_oe, 32'h00FF_FF0F);

        settle(2);
        done = 1'b1;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule